// File: doc/BRIEF.md
# Block-Selective Flush Shift FIFO

This block is a four-slot FIFO for operand packets that are tagged with the speculative block they belong to. Each packet has a 3-bit block ID and a data payload. When a block is squashed, a flush pulse arrives with an 8-bit mask that has one bit for each in-flight block ID. Every stored packet whose block ID has its mask bit set becomes dead in that same cycle. The packet keeps its slot.

Dead packets are never shown downstream. When a dead packet reaches the head of the queue, it is discarded in one cycle with no output valid, and the live packets behind it move forward. An on/off space signal tells the upstream sender whether a packet may be pushed. Storage is a shift register, so the head is always in slot 0.

Top module: `blkflush_fifo`

## Requirements
- R1: After reset the FIFO is empty: `out_valid_o` is 0 and `space_o` is 1.
- R2: Live packets leave in push order, with block ID and payload unchanged. A head packet is consumed in a cycle where `out_valid_o` and `out_ready_i` are both 1.
- R3: `space_o` is 0 exactly when all 4 slots are occupied, and dead packets count as occupied. A push while `space_o` is 0 is ignored and leaves the queue contents unchanged.
- R4: While `out_ready_i` is 0 and no flush hits the head, the head packet stays presented with stable block ID and payload.
- R5: A flush with mask M kills every stored packet whose block ID b has M[b] = 1 (mask bit i stands for block ID i). Packets whose mask bit is 0 are unaffected.
- R6: A dead packet is never presented. When it reaches the head it is dropped within one cycle without `out_valid_o`, and its slot is freed.
- R7: A push in the same cycle as a flush is checked against the mask. If its block ID bit is set, the packet is stored dead.
- R8: If a flush and a head pop happen in the same cycle, the popped head is delivered. Only the remaining packets and any new push are subject to the mask.
- R9: A live packet pushed into an empty FIFO is presented on the outputs in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| push_i | input | 1 | Push request |
| push_blk_i | input | 3 | Block ID of the pushed packet |
| push_data_i | input | DATA_W | Payload of the pushed packet |
| space_o | output | 1 | On/off signal: a slot is free |
| flush_i | input | 1 | Flush pulse |
| flush_mask_i | input | 8 | One bit per block ID to kill |
| out_valid_o | output | 1 | Live head packet presented |
| out_blk_o | output | 3 | Block ID of the head packet |
| out_data_o | output | DATA_W | Payload of the head packet |
| out_ready_i | input | 1 | Downstream accepts the head |

## Verification
Directed sequences cover the following cases:
- Filling the queue to full and pushing into it, which separates counting dead slots as occupied from counting only live ones.
- A mask that hits interleaved block IDs in the middle of the queue, which shows whether the kill is selective and whether dead slots are dropped one per cycle.
- A flush in the same cycle as a push or a pop, which exposes the wrong ordering between shift, kill and store.

Seeded random traffic with sparse random masks and random backpressure then mixes these events and compares every output against a queue model.

// File: rtl/blkflush_pkg.sv
package blkflush_pkg;
  localparam int unsigned BLK_W = 3;
  localparam int unsigned NBLK  = 1 << BLK_W;
  typedef logic [BLK_W-1:0] blk_id_t;
  typedef logic [NBLK-1:0]  blk_mask_t;
endpackage

// File: rtl/blkflush_match.sv
module blkflush_match
  import blkflush_pkg::*;
#(
  parameter int unsigned N = 5
) (
  input  logic      flush_i,
  input  blk_mask_t mask_i,
  input  blk_id_t   blk_i [N],
  output logic [N-1:0] hit_o
);
  for (genvar g = 0; g < N; g++) begin : g_hit
    assign hit_o[g] = flush_i && mask_i[blk_i[g]];
  end
endmodule

// File: rtl/blkflush_ctrl.sv
module blkflush_ctrl #(
  parameter int unsigned DEPTH = 4,
  parameter int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic             head_live_i,
  input  logic             out_ready_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] wpos_o,
  output logic             pop_o,
  output logic             push_ok_o,
  output logic             space_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic head_occ;

  assign head_occ  = (cnt_q != '0);
  // dead head leaves without a handshake
  assign pop_o     = head_occ && (!head_live_i || out_ready_i);
  assign space_o   = (cnt_q < CNT_W'(DEPTH));
  assign push_ok_o = push_i && space_o;
  assign wpos_o    = cnt_q - CNT_W'(pop_o);
  assign cnt_d     = cnt_q + CNT_W'(push_ok_o) - CNT_W'(pop_o);
  assign cnt_o     = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  // R3
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !space_o && push_i && !pop_o |=> !space_o);

  // R3
  full_push_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !space_o && !pop_o |=> cnt_q == $past(cnt_q));

  // R6
  dead_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    head_occ && !head_live_i && !push_ok_o |=> cnt_q == $past(cnt_q) - CNT_W'(1));
endmodule

// File: rtl/blkflush_fifo.sv
module blkflush_fifo
  import blkflush_pkg::*;
#(
  parameter int unsigned DEPTH  = 4,
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  logic [BLK_W-1:0]  push_blk_i,
  input  logic [DATA_W-1:0] push_data_i,
  output logic              space_o,
  input  logic              flush_i,
  input  logic [NBLK-1:0]   flush_mask_i,
  output logic              out_valid_o,
  output logic [BLK_W-1:0]  out_blk_o,
  output logic [DATA_W-1:0] out_data_o,
  input  logic              out_ready_i
);
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);

  blk_id_t           blk_q  [DEPTH];
  logic [DATA_W-1:0] data_q [DEPTH];
  logic [DEPTH-1:0]  live_q;

  blk_id_t           blk_sh  [DEPTH];
  logic [DATA_W-1:0] data_sh [DEPTH];
  logic [DEPTH-1:0]  live_sh;
  blk_id_t           probe   [DEPTH+1];
  logic [DEPTH:0]    hit;

  logic [CNT_W-1:0] cnt, wpos;
  logic pop, push_ok;

  blkflush_ctrl #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .push_i     (push_i),
    .head_live_i(live_q[0]),
    .out_ready_i(out_ready_i),
    .cnt_o      (cnt),
    .wpos_o     (wpos),
    .pop_o      (pop),
    .push_ok_o  (push_ok),
    .space_o    (space_o)
  );

  // shifted view, then mask applied to what survives plus the incoming push
  for (genvar i = 0; i < DEPTH; i++) begin : g_shift
    if (i < DEPTH - 1) begin : g_mid
      assign blk_sh[i]  = pop ? blk_q[i+1]  : blk_q[i];
      assign data_sh[i] = pop ? data_q[i+1] : data_q[i];
      assign live_sh[i] = pop ? live_q[i+1] : live_q[i];
    end else begin : g_tail
      assign blk_sh[i]  = blk_q[i];
      assign data_sh[i] = data_q[i];
      assign live_sh[i] = live_q[i] && !pop;
    end
    assign probe[i] = blk_sh[i];
  end
  assign probe[DEPTH] = push_blk_i;

  blkflush_match #(.N(DEPTH + 1)) u_match (
    .flush_i(flush_i),
    .mask_i (flush_mask_i),
    .blk_i  (probe),
    .hit_o  (hit)
  );

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic wr;
    assign wr = push_ok && (wpos == CNT_W'(i));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        blk_q[i]  <= '0;
        data_q[i] <= '0;
        live_q[i] <= 1'b0;
      end else if (wr) begin
        blk_q[i]  <= push_blk_i;
        data_q[i] <= push_data_i;
        live_q[i] <= !hit[DEPTH];
      end else begin
        blk_q[i]  <= blk_sh[i];
        data_q[i] <= data_sh[i];
        live_q[i] <= live_sh[i] && !hit[i];
      end
    end
  end

  assign out_valid_o = (cnt != '0) && live_q[0];
  assign out_blk_o   = blk_q[0];
  assign out_data_o  = data_q[0];

  // R4
  head_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i && !flush_i |=>
      out_valid_o && $stable(out_data_o) && $stable(out_blk_o));

  // R5
  head_kill_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i && flush_i && flush_mask_i[out_blk_o] |=> !out_valid_o);

  // R9
  empty_push_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt == '0 && push_i && !(flush_i && flush_mask_i[push_blk_i]) |=>
      out_valid_o && out_data_o == $past(push_data_i) && out_blk_o == $past(push_blk_i));

  // R7
  push_kill_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt == '0 && push_i && flush_i && flush_mask_i[push_blk_i] |=> !out_valid_o);
endmodule

// File: tb/blkflush_fifo_bench.sv
module blkflush_fifo_bench;
  localparam int DEPTH  = 4;
  localparam int DATA_W = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic push = 1'b0, flush = 1'b0, ready = 1'b0;
  logic [2:0] push_blk = '0;
  logic [DATA_W-1:0] push_data = '0;
  logic [7:0] mask = '0;
  logic space, out_valid;
  logic [2:0] out_blk;
  logic [DATA_W-1:0] out_data;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  // bench-side queue model
  logic [2:0]        m_blk  [DEPTH];
  logic [DATA_W-1:0] m_data [DEPTH];
  bit                m_live [DEPTH];
  int                m_cnt = 0;

  always #4 clk = ~clk;

  blkflush_fifo #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_blkflush_fifo (
    .clk_i(clk), .rst_ni(rst_n), .push_i(push), .push_blk_i(push_blk),
    .push_data_i(push_data), .space_o(space), .flush_i(flush),
    .flush_mask_i(mask), .out_valid_o(out_valid), .out_blk_o(out_blk),
    .out_data_o(out_data), .out_ready_i(ready)
  );

  task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic bit exp_valid();
    return m_cnt > 0 && m_live[0];
  endfunction

  task automatic model_update(bit p, logic [2:0] b, logic [DATA_W-1:0] d,
                              bit f, logic [7:0] mk, bit r);
    bit pop;
    bit acc;
    pop = m_cnt > 0 && (!m_live[0] || r);
    acc = p && m_cnt < DEPTH;
    if (pop) begin
      for (int i = 0; i < DEPTH - 1; i++) begin
        m_blk[i] = m_blk[i+1]; m_data[i] = m_data[i+1]; m_live[i] = m_live[i+1];
      end
      m_cnt--;
    end
    if (f)
      for (int i = 0; i < m_cnt; i++) if (mk[m_blk[i]]) m_live[i] = 0;
    if (acc) begin
      m_blk[m_cnt] = b; m_data[m_cnt] = d; m_live[m_cnt] = !(f && mk[b]);
      m_cnt++;
    end
  endtask

  // one cycle: compare outputs at negedge, drive, update model, cross posedge
  task automatic step(bit p, logic [2:0] b, logic [DATA_W-1:0] d,
                      bit f, logic [7:0] mk, bit r, string tag);
    @(negedge clk);
    check(tag, "out_valid", 32'(out_valid), 32'(exp_valid()));
    check(tag, "space", 32'(space), 32'(m_cnt < DEPTH));
    if (exp_valid()) begin
      check(tag, "out_data", 32'(out_data), 32'(m_data[0]));
      check(tag, "out_blk", 32'(out_blk), 32'(m_blk[0]));
    end
    push = p; push_blk = b; push_data = d; flush = f; mask = mk; ready = r;
    model_update(p, b, d, f, mk, r);
    @(posedge clk);
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    check("R1", "out_valid", 32'(out_valid), 0);
    check("R1", "space", 32'(space), 1);
    rst_n = 1'b1;

    // R9 push into empty, visible next cycle
    step(1, 3'd4, 16'hA001, 0, 0, 0, "R9");
    step(0, 0, 0, 0, 0, 1, "R9");
    step(0, 0, 0, 0, 0, 1, "R9");

    // R3 fill, push while full ignored, drain in order (R2)
    for (int i = 0; i < DEPTH; i++) step(1, 3'(i), 16'hB000 + 16'(i), 0, 0, 0, "R3");
    step(1, 3'd7, 16'hBEEF, 0, 0, 0, "R3");
    // R4 held while stalled
    step(0, 0, 0, 0, 0, 0, "R4");
    step(0, 0, 0, 0, 0, 0, "R4");
    for (int i = 0; i < DEPTH + 1; i++) step(0, 0, 0, 0, 0, 1, "R2");

    // R5 selective kill of block 2 among 0,2,5,2
    step(1, 3'd0, 16'hC000, 0, 0, 0, "R5");
    step(1, 3'd2, 16'hC001, 0, 0, 0, "R5");
    step(1, 3'd5, 16'hC002, 0, 0, 0, "R5");
    step(1, 3'd2, 16'hC003, 0, 0, 0, "R5");
    step(0, 0, 0, 1, 8'b0000_0100, 0, "R5");
    // R3 dead slots still occupy space
    step(0, 0, 0, 0, 0, 0, "R3");
    // R6 drain: dead entries dropped silently
    for (int i = 0; i < DEPTH + 1; i++) step(0, 0, 0, 0, 0, 1, "R6");

    // R7 push killed by same-cycle flush
    step(1, 3'd3, 16'hD000, 1, 8'b0000_1000, 1, "R7");
    step(1, 3'd1, 16'hD001, 1, 8'b0000_1000, 1, "R7");
    step(0, 0, 0, 0, 0, 1, "R7");
    step(0, 0, 0, 0, 0, 1, "R7");

    // R8 flush together with head pop: head delivered, rest killed
    step(1, 3'd6, 16'hE000, 0, 0, 0, "R8");
    step(1, 3'd6, 16'hE001, 0, 0, 0, "R8");
    step(0, 0, 0, 1, 8'b0100_0000, 1, "R8");
    step(0, 0, 0, 0, 0, 1, "R8");
    step(0, 0, 0, 0, 0, 1, "R8");

    // constrained random mix
    for (int n = 0; n < 4000; n++) begin
      bit p, f, r;
      logic [7:0] mk;
      p  = ($urandom % 100) < 60;
      r  = ($urandom % 100) < 55;
      f  = ($urandom % 100) < 10;
      mk = 8'(1 << ($urandom % 8)) | (($urandom % 4 == 0) ? 8'($urandom) : 8'h00);
      step(p, 3'($urandom), 16'($urandom), f, mk, r, "R2");
    end

    done = 1;
    summary();
    $finish;
  end
endmodule